// File: doc/BRIEF.md
# Thermal Limit Register and Alarm Unit

This block is the digital core of a temperature sensor placed on a memory module. A word-wide synchronous register port gives access to eight 16-bit registers: a capability word, a configuration word, three limits (upper, lower and critical), the temperature readback word and two fixed identity words. A separate input delivers signed temperature samples with a valid strobe. The serial bus slave that drives the register port, the analog front end and the conversion timer all sit outside this block.

Each accepted sample is compared against the three limits. Hysteresis applies to the comparisons and is selected by a 2-bit code in the configuration word. The three alarm flags are returned in the top three bits of the temperature readback word, and an event output reports any alarm that is not masked. Lock bits freeze the limit registers and the hysteresis code. A shutdown bit freezes the sample. A critical-only mode hides the two window alarms.

Top module: `thermal_limit_regs`

## Requirements
- R1: After reset the configuration, all three limits and the temperature word read as 0x0000, and the event output is low.
- R2: Read data is registered. It holds the addressed register one clock after a read strobe. The address map is: 0 capability, 1 configuration, 2 upper limit, 3 lower limit, 4 critical limit, 5 temperature, 6 manufacturer ID, 7 device ID. The capability word reads {8'h00, CAP_LO[7:3], EXT_RANGE, CAP_LO[1:0]}. The IDs read as the parameters MFR_ID and DEV_ID.
- R3: A configuration write stores bits 10:0. Bits 15:11 always read as zero.
- R4: A limit write keeps only bits 12:2. Limit readback has bits 15:13 and bits 1:0 at zero.
- R5: Writes to addresses 0, 5, 6 and 7 have no effect.
- R6: While configuration bit 6 is set, writes to the critical limit are ignored.
- R7: While configuration bit 7 is set, writes to the upper and lower limits are ignored.
- R8: While bit 6 or bit 7 is set at the time of a configuration write, hysteresis bits 10:9 keep their old value. The other bits are written normally.
- R9: While configuration bit 8 is set, samples are ignored, and the temperature value and the flags are held.
- R10: Temperature and limits are 13-bit two's complement values, with 1 LSB = 0.0625 °C. The temperature word reads {crit, upper, lower, sample[12:0]}. A flag sets when the sample is at or above critical (bit 15), above upper (bit 14), or below lower (bit 13). Flags change only on an accepted sample and are visible from the next clock.
- R11: Hysteresis code 0/1/2/3 gives h = 0/24/48/96 LSB. A set critical or upper flag stays set while the sample is at or above limit−h. A set lower flag stays set while the sample is below lower+h. Both limit±h values saturate to the 13-bit range.
- R12: When configuration bit 2 is set, bits 14:13 of the temperature word read as zero and do not drive the event output. The stored flags are not changed.
- R13: The event output is the OR of the unmasked flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| samp_temp | input | 13 | Signed temperature sample |
| samp_valid | input | 1 | Sample strobe |
| alarm_evt | output | 1 | Unmasked alarm event |

## Verification
The bench builds the block with MFR_ID=16'hA5C3, DEV_ID=16'h3C01, EXT_RANGE=1 and CAP_LO=8'h01. With these values the identity and capability reads differ from reset-like patterns, and the extended-range bit is exercised with negative samples. The limits chosen put the temperature on each side of every hysteresis band. A lower limit near the positive end of the range, combined with the 96-LSB code, reaches the saturating addition.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  localparam int REG_W   = 16;
  localparam int TEMP_W  = 13;
  localparam int LIM_LSB = 2;
  localparam int LIM_KW  = TEMP_W - LIM_LSB;
  localparam int CFG_W   = 11;
  localparam int NCH     = 3;

  localparam int CFG_CRIT_ONLY = 2;
  localparam int CFG_LOCK_CRIT = 6;
  localparam int CFG_LOCK_WIN  = 7;
  localparam int CFG_SHDN      = 8;
  localparam int CFG_HYS_LO    = 9;

  localparam int CH_LOW  = 0;
  localparam int CH_HIGH = 1;
  localparam int CH_CRIT = 2;

  typedef enum logic [2:0] {
    A_CAP = 3'd0, A_CFG = 3'd1, A_HI = 3'd2, A_LO = 3'd3,
    A_CRIT = 3'd4, A_TEMP = 3'd5, A_MFR = 3'd6, A_DEV = 3'd7
  } reg_addr_e;

  typedef logic signed [TEMP_W-1:0] temp_t;

  function automatic temp_t hyst_lsb(input logic [1:0] code);
    case (code)
      2'd0:    return temp_t'(0);
      2'd1:    return temp_t'(24);
      2'd2:    return temp_t'(48);
      default: return temp_t'(96);
    endcase
  endfunction

  function automatic temp_t sat_fix(input logic signed [TEMP_W:0] d);
    if (d[TEMP_W] != d[TEMP_W-1])
      return d[TEMP_W] ? {1'b1, {(TEMP_W-1){1'b0}}} : {1'b0, {(TEMP_W-1){1'b1}}};
    return d[TEMP_W-1:0];
  endfunction

  function automatic temp_t sat_add(input temp_t a, input temp_t b);
    return sat_fix({a[TEMP_W-1], a} + {b[TEMP_W-1], b});
  endfunction

  function automatic temp_t sat_sub(input temp_t a, input temp_t b);
    return sat_fix({a[TEMP_W-1], a} - {b[TEMP_W-1], b});
  endfunction
endpackage

// File: rtl/tsense_regs.sv
module tsense_regs
  import tsense_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [2:0]         addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [CFG_W-1:0]   cfg,
  output temp_t              lim_hi,
  output temp_t              lim_lo,
  output temp_t              lim_crit
);
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [LIM_KW-1:0] hi_q, hi_d, lo_q, lo_d, crit_q, crit_d;
  logic              win_locked, crit_locked;

  assign win_locked  = cfg_q[CFG_LOCK_WIN];
  assign crit_locked = cfg_q[CFG_LOCK_CRIT];

  always_comb begin
    cfg_d  = cfg_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    crit_d = crit_q;
    if (wr) begin
      case (reg_addr_e'(addr))
        A_CFG: begin
          cfg_d = wdata[CFG_W-1:0];
          if (win_locked || crit_locked)
            cfg_d[CFG_HYS_LO+1:CFG_HYS_LO] = cfg_q[CFG_HYS_LO+1:CFG_HYS_LO];
        end
        A_HI:   if (!win_locked)  hi_d   = wdata[TEMP_W-1:LIM_LSB];
        A_LO:   if (!win_locked)  lo_d   = wdata[TEMP_W-1:LIM_LSB];
        A_CRIT: if (!crit_locked) crit_d = wdata[TEMP_W-1:LIM_LSB];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      crit_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      crit_q <= crit_d;
    end
  end

  assign cfg      = cfg_q;
  assign lim_hi   = {hi_q,   {LIM_LSB{1'b0}}};
  assign lim_lo   = {lo_q,   {LIM_LSB{1'b0}}};
  assign lim_crit = {crit_q, {LIM_LSB{1'b0}}};

  assert_crit_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CRIT && crit_locked) |=> $stable(lim_crit));
  assert_win_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == A_HI || addr == A_LO) && win_locked) |=> ($stable(lim_hi) && $stable(lim_lo)));
  assert_hyst_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CFG && (win_locked || crit_locked))
      |=> $stable(cfg[CFG_HYS_LO+1:CFG_HYS_LO]));
endmodule

// File: rtl/tsense_alarm.sv
module tsense_alarm
  import tsense_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  temp_t          samp,
  input  logic           samp_valid,
  input  logic           shutdown,
  input  logic [1:0]     hys_code,
  input  temp_t          lim_hi,
  input  temp_t          lim_lo,
  input  temp_t          lim_crit,
  output temp_t          temp,
  output logic [NCH-1:0] flags
);
  temp_t          temp_q, hys;
  logic [NCH-1:0] flag_q, flag_d;
  logic           accept;

  assign accept = samp_valid && !shutdown;
  assign hys    = hyst_lsb(hys_code);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    temp_t lim, rel;
    logic  set_c, hold_c;
    if (g == CH_LOW) begin : g_low
      assign lim    = lim_lo;
      assign rel    = sat_add(lim, hys);
      assign set_c  = samp < lim;
      assign hold_c = samp < rel;
    end else begin : g_up
      assign lim    = (g == CH_CRIT) ? lim_crit : lim_hi;
      assign rel    = sat_sub(lim, hys);
      assign set_c  = (g == CH_CRIT) ? (samp >= lim) : (samp > lim);
      assign hold_c = samp >= rel;
    end
    assign flag_d[g] = set_c || (flag_q[g] && hold_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      flag_q <= '0;
    end else if (accept) begin
      temp_q <= samp;
      flag_q <= flag_d;
    end
  end

  assign temp  = temp_q;
  assign flags = flag_q;

  assert_shutdown_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && shutdown) |=> ($stable(temp) && $stable(flags)));
  assert_crit_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && samp >= lim_crit) |=> flags[CH_CRIT]);
  assert_high_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && samp < sat_sub(lim_hi, hys)) |=> !flags[CH_HIGH]);
endmodule

// File: rtl/thermal_limit_regs.sv
module thermal_limit_regs
  import tsense_pkg::*;
#(
  parameter logic [15:0] MFR_ID    = 16'h0001,
  parameter logic [15:0] DEV_ID    = 16'h0001,
  parameter logic        EXT_RANGE = 1'b1,
  parameter logic [7:0]  CAP_LO    = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  input  logic        reg_wr,
  input  logic        reg_rd,
  output logic [15:0] reg_rdata,
  input  logic [12:0] samp_temp,
  input  logic        samp_valid,
  output logic        alarm_evt
);
  localparam logic [REG_W-1:0] CAP_WORD = {8'h00, CAP_LO[7:3], EXT_RANGE, CAP_LO[1:0]};

  logic [CFG_W-1:0] cfg;
  temp_t            lim_hi, lim_lo, lim_crit, temp;
  logic [NCH-1:0]   flags, vis_flags;
  logic [REG_W-1:0] rdata_q, rdata_d;

  tsense_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cfg      (cfg),
    .lim_hi   (lim_hi),
    .lim_lo   (lim_lo),
    .lim_crit (lim_crit)
  );

  tsense_alarm u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp       (temp_t'(samp_temp)),
    .samp_valid (samp_valid),
    .shutdown   (cfg[CFG_SHDN]),
    .hys_code   (cfg[CFG_HYS_LO+1:CFG_HYS_LO]),
    .lim_hi     (lim_hi),
    .lim_lo     (lim_lo),
    .lim_crit   (lim_crit),
    .temp       (temp),
    .flags      (flags)
  );

  always_comb begin
    vis_flags = flags;
    if (cfg[CFG_CRIT_ONLY]) begin
      vis_flags[CH_LOW]  = 1'b0;
      vis_flags[CH_HIGH] = 1'b0;
    end
  end

  assign alarm_evt = |vis_flags;

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_CAP:   rdata_d = CAP_WORD;
      A_CFG:   rdata_d = {{(REG_W-CFG_W){1'b0}}, cfg};
      A_HI:    rdata_d = {{(REG_W-TEMP_W){1'b0}}, lim_hi};
      A_LO:    rdata_d = {{(REG_W-TEMP_W){1'b0}}, lim_lo};
      A_CRIT:  rdata_d = {{(REG_W-TEMP_W){1'b0}}, lim_crit};
      A_TEMP:  rdata_d = {vis_flags[CH_CRIT], vis_flags[CH_HIGH], vis_flags[CH_LOW], temp};
      A_MFR:   rdata_d = MFR_ID;
      default: rdata_d = DEV_ID;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  assert_crit_only_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[CFG_CRIT_ONLY] && !flags[CH_CRIT]) |-> !alarm_evt);
  assert_event_or_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[CH_CRIT]) |-> alarm_evt);
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/thermal_limit_regs_tb.sv
module thermal_limit_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_rdata;
  logic [12:0] samp_temp;
  logic        samp_valid;
  logic        alarm_evt;

  int vecs  = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  thermal_limit_regs #(
    .MFR_ID(16'hA5C3), .DEV_ID(16'h3C01), .EXT_RANGE(1'b1), .CAP_LO(8'h01)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .samp_temp(samp_temp), .samp_valid(samp_valid), .alarm_evt(alarm_evt)
  );

  // monitor: pop expected read data one clock after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        if (exp_q.size() != 0) begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          vecs++;
          if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
          end
        end
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic sample(input logic [12:0] v);
    @(negedge clk);
    samp_temp = v; samp_valid = 1'b1;
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  task automatic evt_chk(input logic e, input string t);
    vecs++;
    if (alarm_evt !== e) begin
      fails++;
      $display("FAIL %s: alarm_evt actual %b expected %b", t, alarm_evt, e);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 0; reg_rd = 0;
    samp_temp = '0; samp_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    evt_chk(1'b0, "R1 event after reset");
    rd_chk(3'd1, 16'h0000, "R1 cfg reset");
    rd_chk(3'd2, 16'h0000, "R1 upper reset");
    rd_chk(3'd3, 16'h0000, "R1 lower reset");
    rd_chk(3'd4, 16'h0000, "R1 crit reset");
    rd_chk(3'd5, 16'h0000, "R1 temp reset");
    // R2 map, identity and capability
    rd_chk(3'd0, 16'h0005, "R2 capability");
    rd_chk(3'd6, 16'hA5C3, "R2 mfr id");
    rd_chk(3'd7, 16'h3C01, "R2 dev id");
    // R3 config width
    wr_reg(3'd1, 16'hF803);
    rd_chk(3'd1, 16'h0003, "R3 cfg upper bits zero");
    wr_reg(3'd1, 16'h0000);
    // R4 limit storage
    wr_reg(3'd2, 16'hFFFF);
    rd_chk(3'd2, 16'h1FFC, "R4 upper storage");
    wr_reg(3'd2, 16'h0140);
    wr_reg(3'd3, 16'h0050);
    wr_reg(3'd4, 16'h0503);
    rd_chk(3'd4, 16'h0500, "R4 crit low bits");
    // R5 read-only addresses
    wr_reg(3'd5, 16'h0123);
    rd_chk(3'd5, 16'h0000, "R5 temp write ignored");
    wr_reg(3'd6, 16'h0000);
    rd_chk(3'd6, 16'hA5C3, "R5 mfr write ignored");
    wr_reg(3'd0, 16'hFFFF);
    rd_chk(3'd0, 16'h0005, "R5 cap write ignored");
    // R10 flags and format
    sample(13'd100);
    evt_chk(1'b0, "R13 no alarm in window");
    rd_chk(3'd5, 16'h0064, "R10 in window");
    sample(13'h1FF6);
    evt_chk(1'b1, "R13 lower alarm event");
    rd_chk(3'd5, 16'h3FF6, "R10 negative below lower");
    sample(13'd320);
    evt_chk(1'b0, "R10 equal upper no alarm");
    rd_chk(3'd5, 16'h0140, "R10 at upper");
    sample(13'd321);
    evt_chk(1'b1, "R10 above upper event");
    rd_chk(3'd5, 16'h4141, "R10 above upper");
    // R11 hysteresis code 2 = 48 LSB
    wr_reg(3'd1, 16'h0400);
    sample(13'd300);
    rd_chk(3'd5, 16'h412C, "R11 upper held in band");
    sample(13'd271);
    evt_chk(1'b0, "R11 upper released");
    rd_chk(3'd5, 16'h010F, "R11 upper cleared");
    sample(13'd1280);
    rd_chk(3'd5, 16'hC500, "R10 crit at limit");
    sample(13'd1240);
    rd_chk(3'd5, 16'hC4D8, "R11 crit held");
    sample(13'd1231);
    rd_chk(3'd5, 16'h44CF, "R11 crit cleared");
    // R12 critical-only mode
    wr_reg(3'd1, 16'h0404);
    evt_chk(1'b0, "R12 window masked event");
    rd_chk(3'd5, 16'h04CF, "R12 window flag masked");
    sample(13'd1300);
    evt_chk(1'b1, "R12 crit still drives event");
    rd_chk(3'd5, 16'h8514, "R12 crit visible");
    wr_reg(3'd1, 16'h0400);
    rd_chk(3'd5, 16'hC514, "R12 stored flags kept");
    // R11 lower hysteresis
    sample(13'd70);
    rd_chk(3'd5, 16'h2046, "R11 lower set");
    sample(13'd100);
    evt_chk(1'b1, "R11 lower held event");
    rd_chk(3'd5, 16'h2064, "R11 lower held");
    sample(13'd128);
    evt_chk(1'b0, "R11 lower released");
    rd_chk(3'd5, 16'h0080, "R11 lower cleared");
    // R11 saturation with code 3
    wr_reg(3'd1, 16'h0600);
    wr_reg(3'd4, 16'h1000);
    rd_chk(3'd4, 16'h1000, "R4 most negative crit");
    sample(13'h1000);
    rd_chk(3'd5, 16'hB000, "R10 most negative sample");
    wr_reg(3'd3, 16'h0FFC);
    sample(13'h0FA0);
    rd_chk(3'd5, 16'hEFA0, "R10 all flags");
    sample(13'h0FFE);
    rd_chk(3'd5, 16'hEFFE, "R11 lower saturating add");
    // R6 R7 R8 locks
    wr_reg(3'd1, 16'h0640);
    wr_reg(3'd4, 16'h0200);
    rd_chk(3'd4, 16'h1000, "R6 crit locked");
    wr_reg(3'd2, 16'h0200);
    rd_chk(3'd2, 16'h0200, "R6 upper unaffected");
    wr_reg(3'd1, 16'h00C0);
    rd_chk(3'd1, 16'h06C0, "R8 hyst frozen");
    wr_reg(3'd3, 16'h0100);
    rd_chk(3'd3, 16'h0FFC, "R7 lower locked");
    wr_reg(3'd2, 16'h0040);
    rd_chk(3'd2, 16'h0200, "R7 upper locked");
    wr_reg(3'd1, 16'h0000);
    rd_chk(3'd1, 16'h0600, "R8 unlock write keeps hyst");
    // R9 shutdown
    wr_reg(3'd1, 16'h0100);
    sample(13'd200);
    evt_chk(1'b1, "R9 flags held in shutdown");
    rd_chk(3'd5, 16'hEFFE, "R9 sample ignored");
    wr_reg(3'd1, 16'h0000);
    sample(13'd200);
    rd_chk(3'd5, 16'hA0C8, "R9 sample accepted after wake");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: pending reads actual %0d expected 0", exp_q.size());
    end
    summary();
  end
endmodule